// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 32 interrupt sources and drives a single interrupt request line towards a processor. Software sets each source's trigger type (active-high level, active-low level, rising edge or falling edge), gives it a 3-bit priority, and stores a 32-bit vector for it. Sources are turned on and off through separate set and clear command words, so no read-modify-write of a shared mask is needed. The resulting mask can be read back.

When the processor takes the interrupt it reads the vector register. The read returns the vector of the best enabled pending source and records that source's priority on an 8-entry nesting stack. From then on only a strictly higher priority can raise the request line again. A write to the end-of-interrupt register drops one nesting level. If nothing is eligible, the vector read returns a programmable spurious value and leaves the stack alone. Edge sources keep a pending latch. That latch is cleared either by the vector read that serves the source or by the clear command.

Top module: `prio_irq_ctrl`

Register map (word addresses): 0x00–0x1F source mode, 0x20–0x3F source vector, 0x40 vector/acknowledge read, 0x41 spurious vector, 0x42 end-of-interrupt, 0x43 enable command, 0x44 disable command, 0x45 enable mask, 0x46 edge-clear command, 0x47 raw pending.

## Requirements
- R1: A write to 0x43 sets the enable bit of every source whose data bit is 1. A write to 0x44 clears the enable bit of every source whose data bit is 1. Data bits that are 0 leave their enable bits unchanged.
- R2: A read of 0x45 returns the current enable mask, with bit i belonging to source i.
- R3: Source mode register i (address i) holds the priority in bits [2:0] and the trigger type in bits [5:4]. The trigger codes are 0 = high level, 1 = rising edge, 2 = low level, 3 = falling edge. Vector register i (address 0x20+i) holds 32 bits. Both registers read back what was written.
- R4: Trigger codes 2 and 3 act as written only for sources 25 and above. For sources 0 to 24, code 2 acts as high level and code 3 acts as rising edge.
- R5: irq_out is 1 exactly when some enabled pending source has a priority strictly greater than the top of the nesting stack, or when the stack is empty and some enabled source is pending.
- R6: When irq_out is 1, a read of 0x40 returns the winning source's vector and pushes that source's priority onto the stack. When irq_out is 0, the read returns the spurious register (0x41) and leaves the stack unchanged.
- R7: The nesting stack holds 8 levels. Each write of any value to 0x42 pops one level, so 8 such writes always empty a full stack.
- R8: A write to 0x42 while the stack is empty has no effect.
- R9: An edge source latches pending on its selected edge of the synchronized input. The latch is cleared by a 1 in the corresponding bit of a write to 0x46, and also by a vector read that selects that source.
- R10: Among enabled pending sources that share the highest priority, the lowest source number wins.
- R11: After reset, all sources are disabled, the stack is empty, and all mode, vector and spurious registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_src | input | 32 | Raw interrupt source lines, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data is valid in the following cycle |
| bus_addr | input | 7 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The checker watches several rules on every cycle:
- Each enable or disable command leaves the named mask bits set or clear.
- The request line is never raised without an enabled pending source.
- Every vector read either pushes exactly one level or returns the spurious value.
- The stack never grows past eight entries.
- An end-of-interrupt write on an empty stack changes nothing.

Some behaviours can only be shown by the bench's scenarios:
- Priority choice and the lowest-number tie-break, compared against a reference model across random configurations.
- Edge latching and its two clearing paths.
- The remapping of low and falling codes on internal sources.
- A full eight-level nesting sequence, with pops followed by a re-raised request.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    TRIG_HIGH = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_LOW  = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  // bit position of the trigger field inside a mode register
  localparam int TRIG_LSB = 4;

  // offsets of the command/status words above the two per-source banks
  localparam int OFS_IVR  = 0;
  localparam int OFS_SPUR = 1;
  localparam int OFS_EOI  = 2;
  localparam int OFS_ENA  = 3;
  localparam int OFS_DIS  = 4;
  localparam int OFS_MASK = 5;
  localparam int OFS_CLR  = 6;
  localparam int OFS_PEND = 7;
endpackage

// File: rtl/pic_rst_sync.sv
module pic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_q = sh_q[1];
endmodule

// File: rtl/pic_src_cond.sv
module pic_src_cond #(
  parameter int N_SRC    = 32,
  parameter int EXT_BASE = 25
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_SRC-1:0]      irq_src,
  input  logic [N_SRC-1:0][1:0] trig,
  input  logic [N_SRC-1:0]      clr_edge,
  output logic [N_SRC-1:0]      pending
);
  logic [N_SRC-1:0] s1_q, s2_q, s3_q, lat_q, lat_d;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic [1:0] eff;
    logic       lvl, prev, hit;
    if (g >= EXT_BASE) begin : g_ext
      assign eff = trig[g];
    end else begin : g_int
      // internal sources: polarity bit forced off
      assign eff = {1'b0, trig[g][0]};
    end
    assign lvl  = s2_q[g] ^ eff[1];
    assign prev = s3_q[g] ^ eff[1];
    assign hit  = lvl & ~prev;
    assign lat_d[g]   = eff[0] & (hit | (lat_q[g] & ~clr_edge[g]));
    assign pending[g] = eff[0] ? lat_q[g] : lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= '0;
      s2_q  <= '0;
      s3_q  <= '0;
      lat_q <= '0;
    end else begin
      s1_q  <= irq_src;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      lat_q <= lat_d;
    end
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 3,
  localparam int IDW   = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]             pend_en,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
  output logic                         found,
  output logic [IDW-1:0]               win_id,
  output logic [PRIO_W-1:0]            win_prio
);
  always_comb begin
    found    = 1'b0;
    win_id   = '0;
    win_prio = '0;
    // scan downwards with >= so the lowest index wins a tie
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_en[i] && (!found || prio[i] >= win_prio)) begin
        found    = 1'b1;
        win_id   = IDW'(i);
        win_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/pic_nest.sv
module pic_nest #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  localparam int DW    = $clog2(DEPTH + 1),
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  output logic [DW-1:0]     depth,
  output logic              top_valid,
  output logic [PRIO_W-1:0] top_prio
);
  logic [DEPTH-1:0][PRIO_W-1:0] stk_q, stk_d;
  logic [DW-1:0]                depth_q, depth_d, top_idx;

  always_comb begin
    stk_d   = stk_q;
    depth_d = depth_q;
    if (push && depth_q < DW'(DEPTH)) begin
      stk_d[depth_q[AW-1:0]] = push_prio;
      depth_d = depth_q + 1'b1;
    end else if (pop && depth_q != '0) begin
      depth_d = depth_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk_q   <= '0;
      depth_q <= '0;
    end else begin
      stk_q   <= stk_d;
      depth_q <= depth_d;
    end
  end

  assign top_idx   = depth_q - 1'b1;
  assign top_valid = depth_q != '0;
  assign top_prio  = stk_q[top_idx[AW-1:0]];
  assign depth     = depth_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_SRC    = 32,
  parameter int PRIO_W   = 3,
  parameter int NEST     = 8,
  parameter int EXT_BASE = 25,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_src,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  localparam int IDW = $clog2(N_SRC);
  localparam int DW  = $clog2(NEST + 1);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(N_SRC);
  localparam logic [ADDR_W-1:0] A_IVR  = ADDR_W'(2 * N_SRC + OFS_IVR);
  localparam logic [ADDR_W-1:0] A_SPUR = ADDR_W'(2 * N_SRC + OFS_SPUR);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(2 * N_SRC + OFS_EOI);
  localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(2 * N_SRC + OFS_ENA);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(2 * N_SRC + OFS_DIS);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(2 * N_SRC + OFS_MASK);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(2 * N_SRC + OFS_CLR);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(2 * N_SRC + OFS_PEND);

  logic                          rst_q;
  logic [N_SRC-1:0][PRIO_W-1:0]  prio_q, prio_d;
  logic [N_SRC-1:0][1:0]         trig_q, trig_d;
  logic [N_SRC-1:0][DATA_W-1:0]  vec_q, vec_d;
  logic [N_SRC-1:0]              en_q, en_d;
  logic [DATA_W-1:0]             spur_q, spur_d, rdata_q, rdata_d, rd_mux;
  logic [N_SRC-1:0]              pending, pend_en, clr_edge;
  logic [IDW-1:0]                idx, win_id;
  logic [PRIO_W-1:0]             win_prio, top_prio;
  logic [DW-1:0]                 depth;
  logic                          found, top_valid, in_mode, in_vec;
  logic                          ivr_rd, push, pop;

  pic_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  pic_src_cond #(.N_SRC(N_SRC), .EXT_BASE(EXT_BASE)) u_cond (
    .clk(clk), .rst_n(rst_q), .irq_src(irq_src), .trig(trig_q),
    .clr_edge(clr_edge), .pending(pending)
  );

  pic_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .pend_en(pend_en), .prio(prio_q), .found(found),
    .win_id(win_id), .win_prio(win_prio)
  );

  pic_nest #(.DEPTH(NEST), .PRIO_W(PRIO_W)) u_nest (
    .clk(clk), .rst_n(rst_q), .push(push), .push_prio(win_prio),
    .pop(pop), .depth(depth), .top_valid(top_valid), .top_prio(top_prio)
  );

  // decode
  assign idx     = bus_addr[IDW-1:0];
  assign in_mode = bus_addr < A_VEC;
  assign in_vec  = !in_mode && (bus_addr < A_IVR);
  assign ivr_rd  = bus_rd && (bus_addr == A_IVR);
  assign pop     = bus_wr && (bus_addr == A_EOI);
  assign pend_en = pending & en_q;
  assign irq_out = found && (!top_valid || win_prio > top_prio);
  assign push    = ivr_rd && irq_out;

  always_comb begin
    clr_edge = '0;
    if (bus_wr && bus_addr == A_CLR) clr_edge = bus_wdata[N_SRC-1:0];
    if (push) clr_edge[win_id] = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    if (in_mode) begin
      rd_mux[PRIO_W-1:0]    = prio_q[idx];
      rd_mux[TRIG_LSB +: 2] = trig_q[idx];
    end else if (in_vec) begin
      rd_mux = vec_q[idx];
    end else begin
      case (bus_addr)
        A_IVR:   rd_mux = irq_out ? vec_q[win_id] : spur_q;
        A_SPUR:  rd_mux = spur_q;
        A_MASK:  rd_mux[N_SRC-1:0] = en_q;
        A_PEND:  rd_mux[N_SRC-1:0] = pending;
        default: rd_mux = '0;
      endcase
    end
  end

  // next state
  always_comb begin
    prio_d  = prio_q;
    trig_d  = trig_q;
    vec_d   = vec_q;
    en_d    = en_q;
    spur_d  = spur_q;
    rdata_d = rdata_q;
    if (bus_wr) begin
      if (in_mode) begin
        prio_d[idx] = bus_wdata[PRIO_W-1:0];
        trig_d[idx] = bus_wdata[TRIG_LSB +: 2];
      end else if (in_vec) begin
        vec_d[idx] = bus_wdata;
      end else begin
        case (bus_addr)
          A_SPUR:  spur_d = bus_wdata;
          A_ENA:   en_d   = en_q | bus_wdata[N_SRC-1:0];
          A_DIS:   en_d   = en_q & ~bus_wdata[N_SRC-1:0];
          default: ;
        endcase
      end
    end
    if (bus_rd) rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      prio_q  <= '0;
      trig_q  <= '0;
      vec_q   <= '0;
      en_q    <= '0;
      spur_q  <= '0;
      rdata_q <= '0;
    end else begin
      prio_q  <= prio_d;
      trig_q  <= trig_d;
      vec_q   <= vec_d;
      en_q    <= en_d;
      spur_q  <= spur_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/pic_checker.sv
module pic_checker
  import pic_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int NEST   = 8,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  localparam int DW    = $clog2(NEST + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_out,
  input logic [DW-1:0]     depth,
  input logic [N_SRC-1:0]  pend_en,
  input logic [N_SRC-1:0]  mask,
  input logic [DATA_W-1:0] spur
);
  localparam logic [ADDR_W-1:0] A_IVR = ADDR_W'(2 * N_SRC + OFS_IVR);
  localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(2 * N_SRC + OFS_EOI);
  localparam logic [ADDR_W-1:0] A_ENA = ADDR_W'(2 * N_SRC + OFS_ENA);
  localparam logic [ADDR_W-1:0] A_DIS = ADDR_W'(2 * N_SRC + OFS_DIS);

  p_ena_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ENA) |=>
      ((mask & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

  p_dis_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIS) |=> ((mask & $past(bus_wdata[N_SRC-1:0])) == '0));

  p_irq_has_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pend_en != '0));

  p_ack_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_IVR && irq_out && !bus_wr) |=> (depth == $past(depth) + 1'b1));

  p_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_IVR && !irq_out && !bus_wr) |=>
      (bus_rdata == $past(spur) && depth == $past(depth)));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(NEST));

  p_eoi_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_EOI && depth == '0 && !bus_rd) |=> (depth == '0));
endmodule

bind prio_irq_ctrl pic_checker #(
  .N_SRC(N_SRC), .NEST(NEST), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_q), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_out(irq_out), .depth(depth), .pend_en(pend_en), .mask(en_q),
  .spur(spur_q)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam logic [6:0] A_VEC = 7'h20, A_IVR = 7'h40, A_SPUR = 7'h41, A_EOI = 7'h42,
                         A_ENA = 7'h43, A_DIS = 7'h44, A_MASK = 7'h45, A_CLR = 7'h46;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_chk = 0, n_bad = 0;

  int          m_prio [32];
  logic [1:0]  m_trig [32];
  logic [31:0] m_vec  [32];
  logic [31:0] m_en, m_spur;
  int          m_stk  [8];
  int          m_depth;

  always #5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_src(src), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    summary();
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic settle(); repeat (4) @(negedge clk); endtask

  task automatic cfg(input int i, input int p, input logic [1:0] t, input logic [31:0] v);
    m_prio[i] = p; m_trig[i] = t; m_vec[i] = v;
    wr(7'(i), {26'd0, t, 1'b0, 3'(p)});
    wr(A_VEC + 7'(i), v);
  endtask

  // model for level-only configurations
  function automatic void model_win(output bit fnd, output int wid, output int wp);
    fnd = 0; wid = 0; wp = 0;
    for (int i = 0; i < 32; i++) begin
      logic [1:0] eff;
      bit act;
      eff = (i >= 25) ? m_trig[i] : {1'b0, m_trig[i][0]};
      act = eff[1] ? !src[i] : src[i];
      if (act && m_en[i] && (!fnd || m_prio[i] > wp)) begin
        fnd = 1; wid = i; wp = m_prio[i];
      end
    end
  endfunction

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 irq_out", {31'd0, irq_out}, 32'd0);
    rd(A_MASK, d);        chk("R11 mask", d, 32'd0);
    rd(7'd7, d);          chk("R11 mode", d, 32'd0);
    rd(A_VEC + 7'd7, d);  chk("R11 vector", d, 32'd0);
    rd(A_IVR, d);         chk("R11 spurious reset", d, 32'd0);

    // R1 / R2 enable and disable
    wr(A_ENA, 32'h0000_00F0);
    wr(A_DIS, 32'h0000_0030);
    rd(A_MASK, d); chk("R1 R2 mask", d, 32'h0000_00C0);
    wr(A_ENA, 32'h8000_0000);
    rd(A_MASK, d); chk("R1 zero bits keep", d, 32'h8000_00C0);
    wr(A_DIS, 32'hFFFF_FFFF);

    // R3 mode/vector readback
    wr(7'd12, 32'h0000_0025);
    rd(7'd12, d); chk("R3 mode", d, 32'h0000_0025);
    wr(A_VEC + 7'd12, 32'hCAFE_0012);
    rd(A_VEC + 7'd12, d); chk("R3 vector", d, 32'hCAFE_0012);

    // R6 spurious register
    wr(A_SPUR, 32'h0000_DEAD); m_spur = 32'h0000_DEAD;
    rd(A_IVR, d); chk("R6 spurious", d, 32'h0000_DEAD);

    // R10 tie break
    cfg(3, 4, 2'd0, 32'h33); cfg(9, 4, 2'd0, 32'h99);
    src[3] = 1'b1; src[9] = 1'b1; settle();
    wr(A_ENA, 32'h0000_0208);
    rd(A_IVR, d); chk("R10 lowest id wins", d, 32'h33);
    wr(A_EOI, 0); wr(A_DIS, 32'hFFFF_FFFF); src = '0; settle();

    // R9 rising edge latch, cleared by acknowledge and by clear command
    cfg(5, 2, 2'd1, 32'h55); wr(A_ENA, 32'h20);
    src[5] = 1'b1; settle(); src[5] = 1'b0; settle();
    chk("R9 edge latched", {31'd0, irq_out}, 32'd1);
    rd(A_IVR, d); chk("R9 edge vector", d, 32'h55);
    wr(A_EOI, 0);
    chk("R9 ack clears latch", {31'd0, irq_out}, 32'd0);
    src[5] = 1'b1; settle(); src[5] = 1'b0; settle();
    chk("R9 second edge", {31'd0, irq_out}, 32'd1);
    wr(A_CLR, 32'h20);
    chk("R9 clear command", {31'd0, irq_out}, 32'd0);
    wr(A_DIS, 32'hFFFF_FFFF);

    // R4 falling edge on external source 26
    src[26] = 1'b1; settle();
    cfg(26, 1, 2'd3, 32'h26); wr(A_ENA, 32'h0400_0000);
    chk("R4 ext fall idle", {31'd0, irq_out}, 32'd0);
    src[26] = 1'b0; settle();
    chk("R4 ext falling edge", {31'd0, irq_out}, 32'd1);
    rd(A_IVR, d); chk("R4 ext fall vector", d, 32'h26);
    wr(A_EOI, 0); wr(A_DIS, 32'hFFFF_FFFF);

    // R4 falling code on internal source 6 acts as rising
    src[6] = 1'b1; settle();
    cfg(6, 3, 2'd3, 32'h66); wr(A_ENA, 32'h40);
    src[6] = 1'b0; settle();
    chk("R4 int fall ignored", {31'd0, irq_out}, 32'd0);
    src[6] = 1'b1; settle();
    chk("R4 int acts rising", {31'd0, irq_out}, 32'd1);
    rd(A_IVR, d); chk("R4 int vector", d, 32'h66);
    wr(A_EOI, 0); wr(A_DIS, 32'hFFFF_FFFF);

    // R4 active low on external source 27
    src[27] = 1'b1;
    cfg(27, 2, 2'd2, 32'h27); wr(A_ENA, 32'h0800_0000); settle();
    chk("R4 ext low idle", {31'd0, irq_out}, 32'd0);
    src[27] = 1'b0; settle();
    chk("R4 ext low active", {31'd0, irq_out}, 32'd1);
    wr(A_DIS, 32'hFFFF_FFFF); src = '0; settle();

    // R7 full nesting, R5 strict priority, R8 empty end-of-interrupt
    for (int k = 0; k < 8; k++) cfg(8 + k, k, 2'd0, 32'h100 + 32'(8 + k));
    src[15:8] = 8'hFF; settle();
    for (int k = 0; k < 8; k++) begin
      wr(A_ENA, 32'h1 << (8 + k));
      chk("R5 higher level raises", {31'd0, irq_out}, 32'd1);
      rd(A_IVR, d); chk("R6 R7 nest vector", d, 32'h100 + 32'(8 + k));
    end
    chk("R7 full stack quiet", {31'd0, irq_out}, 32'd0);
    wr(A_EOI, 0);
    chk("R7 pop re-raises", {31'd0, irq_out}, 32'd1);
    wr(A_DIS, 32'hFFFF_FFFF);
    for (int k = 0; k < 7; k++) wr(A_EOI, 0);
    wr(A_EOI, 0);
    wr(A_ENA, 32'h100);
    chk("R7 R8 stack empty", {31'd0, irq_out}, 32'd1);
    rd(A_IVR, d); chk("R8 vector after empty eoi", d, 32'h108);
    chk("R5 equal level blocked", {31'd0, irq_out}, 32'd0);
    wr(A_EOI, 0);
    chk("R8 single pop", {31'd0, irq_out}, 32'd1);
    wr(A_DIS, 32'hFFFF_FFFF); src = '0; settle();

    // random level configurations against the model (R2 R4 R5 R6 R10)
    m_depth = 0;
    for (int it = 0; it < 40; it++) begin
      for (int i = 0; i < 32; i++)
        cfg(i, int'($urandom_range(7)), ($urandom_range(1) != 0) ? 2'd2 : 2'd0, $urandom);
      m_en = $urandom;
      wr(A_DIS, 32'hFFFF_FFFF); wr(A_ENA, m_en);
      src = $urandom; settle();
      rd(A_MASK, d); chk("R2 random mask", d, m_en);
      for (int r = 0; r < 3; r++) begin
        bit fnd; int wid, wp; bit exp_irq;
        model_win(fnd, wid, wp);
        exp_irq = fnd && (m_depth == 0 || wp > m_stk[m_depth - 1]);
        chk("R5 random irq", {31'd0, irq_out}, {31'd0, exp_irq});
        rd(A_IVR, d);
        chk("R6 R10 random vector", d, exp_irq ? m_vec[wid] : m_spur);
        if (exp_irq) begin m_stk[m_depth] = wp; m_depth++; end
      end
      for (int e = 0; e <= m_depth; e++) wr(A_EOI, 0);
      m_depth = 0;
    end

    summary();
  end
endmodule